// File: doc/BRIEF.md
# Configurable SPI Master/Slave Byte Transceiver

This block moves one data byte at a time over a four-wire serial link. The same shift engine works either as the clock-generating end of the link or as the clock-following end, chosen at run time. An 8-bit settings register selects that role. It also selects the bit order, the idle level of the serial clock, which clock edge samples, and one of four clock dividers for the generating role. One further bit exchanges the jobs of the two data pins, which lets a single shared wire carry traffic in both directions.

Software writes the settings first. It then offers a byte on the transmit stream. In the generating role, accepting that byte starts a transfer of eight clock periods. In the following role, the accepted byte waits in the shift register until an external device pulls slave-select low and clocks it out. The received byte appears on the receive stream at the end of the transfer.

Back-pressure works as follows. `tx_ready` is high only while the engine is enabled and idle. A byte offered while `tx_ready` is low is not taken. `rx_valid` stays high until `rx_ready` is seen with it. A transfer that completes while an earlier byte is still waiting replaces that byte.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the settings read back as 0x00, all three pin output enables are low, `tx_ready` is low and `rx_valid` is low.
- R2: A settings write is read back unchanged on `cfg_rdata` on the next cycle. The field layout is: bit 7 pin swap, bit 6 LSB-first, bits 5:4 role (00 off, 01 clock generator, 10 clock follower, 11 off), bit 3 clock idle level, bit 2 clock phase, bits 1:0 divider select.
- R3: When the role field is 00 or 11, every output enable is low, `tx_ready` is low, a byte offered on the transmit stream produces no received byte, and `sclk_o` equals the idle-level bit.
- R4: In generator role, `sclk_o` rests at the idle-level bit between transfers. A transfer makes exactly 16 clock edges spaced D/2 system cycles apart, with D = 6, 12, 48, 96 for divider select 00, 01, 10, 11. `rx_valid` rises exactly 8·D cycles after the transmit byte is accepted.
- R5: With phase bit 0, data is sampled on leading clock edges and changed on trailing edges, and the first bit is on the pin before the first edge. With phase bit 1, data is changed on leading edges and sampled on trailing edges.
- R6: With LSB-first 0, bit 7 is sent and received first. With LSB-first 1, bit 0 goes first. The rule applies in both directions.
- R7: In generator role with swap 0, the block drives `sclk` and `mosi` and receives on `miso`. With swap 1 it drives `miso` and receives on `mosi`, and `mosi_oe` is low.
- R8: In follower role, `sclk_oe` is low. The transmit pin (`miso` when swap is 0, `mosi` when swap is 1) is enabled only while `ss_n` is low. The block receives on the other pin. `rx_valid` rises within 5 system cycles of the 16th external clock edge.
- R9: `tx_ready` falls on the cycle after a byte is accepted in generator role and stays low until the transfer ends. A byte offered while it is low is ignored, and the transfer in progress sends the byte that was accepted.
- R10: `rx_valid` holds, with `rx_data` unchanged, until a cycle with `rx_ready` high. It is low on the cycle after that handshake.
- R11: In follower role, raising `ss_n` part-way through a transfer abandons it. No byte is delivered, and `tx_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings register write strobe |
| cfg_wdata | input | 8 | Settings value to write |
| cfg_rdata | output | 8 | Current settings value |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine can take a transmit byte |
| tx_data | input | DW | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DW | Received byte |
| ss_n | input | 1 | Active-low slave select (follower role) |
| sclk_i | input | 1 | Serial clock input (follower role) |
| sclk_o | output | 1 | Serial clock output (generator role) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output value |
| mosi_oe | output | 1 | MOSI pin output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO pin output enable |

## Verification
In generator role the received byte is due exactly 8·D cycles after the accepting edge. The bench counts falling system-clock edges from acceptance and checks that count against the divider in use. It also watches every `sclk_o` change at the falling edge after it occurs, acting as the far end and timing the spacing of the edges. In follower role the external clock passes through a two-flop synchroniser and an edge detector, so each action lands 3 cycles after a pin edge. The bench therefore holds every input for 8 cycles per half period and reads the transmit pin only just before the edge that samples it. The settings read-back, the idle-time pin enables and the `tx_ready` state take effect one cycle after their cause, and the bench reads them one falling edge later.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF = 2'b00,
    ROLE_GEN = 2'b01,
    ROLE_FOL = 2'b10,
    ROLE_RSV = 2'b11
  } role_e;

  typedef struct packed {
    logic       swap;
    logic       lsb_first;
    role_e      role;
    logic       idle_hi;
    logic       late_phase;
    logic [1:0] div_sel;
  } settings_t;

  // half of the serial clock period, in system cycles
  function automatic int unsigned half_period(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3;
      2'b01:   return 6;
      2'b10:   return 24;
      default: return 48;
    endcase
  endfunction

endpackage

// File: rtl/spi_xcvr_clkdiv.sv
module spi_xcvr_clkdiv
  import spi_xcvr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'(half_period(sel) - 1);
    tick = run && (cnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_xcvr_edgedet.sv
module spi_xcvr_edgedet #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign edge_o = pipe[STAGES] ^ pipe[STAGES-1];

endmodule

// File: rtl/spi_xcvr_shifter.sv
module spi_xcvr_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lsb_first,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          shift,
  input  logic          sample,
  input  logic          in_bit,
  output logic          out_bit,
  output logic [DW-1:0] rx_word,
  output logic [DW-1:0] rx_next
);

  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;

  always_comb begin
    out_bit = lsb_first ? tx_sr[0] : tx_sr[DW-1];
    rx_next = lsb_first ? {in_bit, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], in_bit};
    rx_word = rx_sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load)       tx_sr <= load_data;
      else if (shift) tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      if (sample)     rx_sr <= rx_next;
    end
  end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          ss_n,
  input  logic          sclk_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe
);

  localparam int EDGES = 2 * DW;
  localparam int ECW   = $clog2(EDGES);

  settings_t      cfg;
  logic           is_gen, is_fol;
  logic           busy_g, phase;
  logic [ECW-1:0] ecnt;
  logic           tick_g, edge_s, ev, leading, sample_ev, change_ev, last_ev;
  logic           accept, tx_bit, rx_bit;
  logic [DW-1:0]  rx_word, rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= settings_t'(cfg_wdata);
  end

  assign cfg_rdata = cfg;
  assign is_gen    = (cfg.role == ROLE_GEN);
  assign is_fol    = (cfg.role == ROLE_FOL);

  spi_xcvr_clkdiv #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(is_gen && busy_g), .sel(cfg.div_sel), .tick(tick_g)
  );

  spi_xcvr_edgedet #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk_i), .edge_o(edge_s)
  );

  always_comb begin
    ev        = tick_g || (is_fol && !ss_n && edge_s);
    leading   = !ecnt[0];
    sample_ev = ev && (leading ^ cfg.late_phase);
    change_ev = ev && !(leading ^ cfg.late_phase) && (ecnt != '0);
    last_ev   = ev && (ecnt == ECW'(EDGES - 1));
    tx_ready  = (is_gen && !busy_g) || (is_fol && ecnt == '0);
    accept    = tx_valid && tx_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_g <= 1'b0;
      phase  <= 1'b0;
      ecnt   <= '0;
    end else if ((!is_gen && !is_fol) || (is_fol && ss_n)) begin
      busy_g <= 1'b0;
      phase  <= 1'b0;
      ecnt   <= '0;
    end else begin
      if (accept && is_gen) busy_g <= 1'b1;
      if (ev) begin
        ecnt <= last_ev ? '0 : ecnt + 1'b1;
        if (is_gen)  phase  <= ~phase;
        if (last_ev) busy_g <= 1'b0;
      end
    end
  end

  spi_xcvr_shifter #(.DW(DW)) u_sh (
    .clk(clk), .rst_n(rst_n), .lsb_first(cfg.lsb_first),
    .load(accept), .load_data(tx_data), .shift(change_ev), .sample(sample_ev),
    .in_bit(rx_bit), .out_bit(tx_bit), .rx_word(rx_word), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (last_ev) begin
      rx_valid <= 1'b1;
      rx_data  <= sample_ev ? rx_next : rx_word;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // pin roles: transmit on mosi when generator xor swap
  always_comb begin
    rx_bit  = (is_gen ^ cfg.swap) ? miso_i : mosi_i;
    mosi_o  = tx_bit;
    miso_o  = tx_bit;
    mosi_oe = (is_gen && !cfg.swap) || (is_fol && cfg.swap && !ss_n);
    miso_oe = (is_gen && cfg.swap) || (is_fol && !cfg.swap && !ss_n);
    sclk_o  = cfg.idle_hi ^ phase;
    sclk_oe = is_gen;
  end

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       ss_n,
  input logic       sclk_o,
  input logic       sclk_oe,
  input logic       mosi_oe,
  input logic       miso_oe
);

  logic off_role, gen_role, fol_role;
  assign off_role = (cfg_rdata[5:4] == 2'b00) || (cfg_rdata[5:4] == 2'b11);
  assign gen_role = (cfg_rdata[5:4] == 2'b01);
  assign fol_role = (cfg_rdata[5:4] == 2'b10);

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_role |-> (!sclk_oe && !mosi_oe && !miso_oe && !tx_ready));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_role && tx_ready) |-> (sclk_o == cfg_rdata[3]));

  // R7
  gen_one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_role |-> (sclk_oe && $onehot0({mosi_oe, miso_oe}) && (mosi_oe || miso_oe)));

  // R8
  fol_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fol_role && ss_n) |-> (!mosi_oe && !miso_oe && !sclk_oe));

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_role && tx_valid && tx_ready) |=> (!tx_ready || !gen_role));

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready), .ss_n(ss_n),
  .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/spi_xcvr_tb.sv
module spi_xcvr_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       ss_n = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sclk_o, sclk_oe;
  logic       mosi_i = 1'b0;
  logic       mosi_o, mosi_oe;
  logic       miso_i = 1'b0;
  logic       miso_o, miso_oe;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  localparam int H = 8;

  always #4 clk = ~clk;

  spi_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ss_n(ss_n), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  function automatic int div_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 6;
      2'b01:   return 12;
      2'b10:   return 48;
      default: return 96;
    endcase
  endfunction

  function automatic int pos_of(input int i, input bit lsb);
    return lsb ? i : 7 - i;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_wdata = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == v, "R2 settings read-back", cfg_rdata, v);
  endtask

  task automatic take_rx(input logic [7:0] exp, input string req);
    chk(rx_valid == 1'b1, req, rx_valid, 1);
    chk(rx_data == exp, req, rx_data, exp);
    repeat (2) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == exp, "R10 hold without ready", rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R10 cleared after handshake", rx_valid, 0);
  endtask

  // bench acts as the far device clocked by the block
  task automatic run_gen(input logic [7:0] cv, input logic [7:0] txb, input logic [7:0] rpl);
    int d = div_of(cv[1:0]);
    bit lsb = cv[6], pha = cv[2], pol = cv[3], swp = cv[7];
    logic [7:0] got = '0;
    int bo = 0, bi = 0, edges = 0, cnt = 0, last_e = 0, bad_gap = 0;
    logic prev, pin;
    cfg_write(cv);
    chk(sclk_o == pol, "R4 idle level", sclk_o, pol);
    chk(sclk_oe && (mosi_oe == !swp) && (miso_oe == swp), "R7 generator enables",
        {sclk_oe, mosi_oe, miso_oe}, {1'b1, !swp, swp});
    chk(tx_ready == 1'b1, "R9 ready when idle", tx_ready, 1);
    pin = rpl[pos_of(0, lsb)];
    if (swp) begin mosi_i = pin; miso_i = ~pin; end else begin miso_i = pin; mosi_i = ~pin; end
    tx_data = txb;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    prev = sclk_o;
    while (cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (cnt == 5) begin
        tx_data = ~txb;
        tx_valid = 1'b1;
        chk(tx_ready == 1'b0, "R9 busy refuses", tx_ready, 0);
      end else if (cnt == 6) begin
        tx_valid = 1'b0;
      end
      if (sclk_o != prev) begin
        if (cnt - last_e != d / 2) bad_gap++;
        last_e = cnt;
        if ((edges % 2 == 0) ^ pha) begin
          got[pos_of(bo, lsb)] = swp ? miso_o : mosi_o;
          bo++;
        end else if (edges != 0) begin
          bi++;
          pin = (bi < 8) ? rpl[pos_of(bi, lsb)] : 1'b0;
          if (swp) begin mosi_i = pin; miso_i = ~pin; end else begin miso_i = pin; mosi_i = ~pin; end
        end
        edges++;
        prev = sclk_o;
      end
      if (rx_valid) break;
    end
    chk(cnt == 8 * d, "R4 completion latency", cnt, 8 * d);
    chk(edges == 16, "R4 edge count", edges, 16);
    chk(bad_gap == 0, "R4 edge spacing", bad_gap, 0);
    chk(sclk_o == pol, "R4 back to idle", sclk_o, pol);
    chk(got == txb, "R5 R6 R9 byte sent", got, txb);
    take_rx(rpl, "R5 R6 R7 byte received");
  endtask

  // bench acts as the clocking device; block is follower
  task automatic run_fol(input logic [7:0] cv, input logic [7:0] txb, input logic [7:0] rpl);
    bit lsb = cv[6], pha = cv[2], pol = cv[3], swp = cv[7];
    logic [7:0] got = '0;
    logic pin;
    ss_n = 1'b1;
    sclk_i = pol;
    cfg_write(cv);
    repeat (4) @(negedge clk);
    chk(!sclk_oe && !mosi_oe && !miso_oe, "R8 deselected enables", {sclk_oe, mosi_oe, miso_oe}, 0);
    chk(tx_ready == 1'b1, "R8 ready before frame", tx_ready, 1);
    tx_data = txb;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sclk_oe && (mosi_oe == swp) && (miso_oe == !swp), "R8 R7 selected enables",
        {sclk_oe, mosi_oe, miso_oe}, {1'b0, swp, !swp});
    for (int i = 0; i < 8; i++) begin
      pin = rpl[pos_of(i, lsb)];
      if (!pha) begin
        if (swp) begin miso_i = pin; mosi_i = ~pin; end else begin mosi_i = pin; miso_i = ~pin; end
        repeat (H) @(negedge clk);
        got[pos_of(i, lsb)] = swp ? mosi_o : miso_o;
        sclk_i = ~sclk_i;
        repeat (H) @(negedge clk);
        sclk_i = ~sclk_i;
      end else begin
        sclk_i = ~sclk_i;
        if (swp) begin miso_i = pin; mosi_i = ~pin; end else begin mosi_i = pin; miso_i = ~pin; end
        repeat (H) @(negedge clk);
        got[pos_of(i, lsb)] = swp ? mosi_o : miso_o;
        sclk_i = ~sclk_i;
        repeat (H) @(negedge clk);
      end
    end
    repeat (5) @(negedge clk);
    chk(got == txb, "R5 R6 R8 follower byte sent", got, txb);
    take_rx(rpl, "R8 follower byte received");
    ss_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    // R1
    chk(cfg_rdata == 8'h00, "R1 settings reset", cfg_rdata, 0);
    chk(!sclk_oe && !mosi_oe && !miso_oe, "R1 enables reset", {sclk_oe, mosi_oe, miso_oe}, 0);
    chk(!tx_ready && !rx_valid, "R1 streams reset", {tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reserved role with high idle level
    cfg_write(8'b1011_1001);
    chk(!sclk_oe && !mosi_oe && !miso_oe && !tx_ready, "R3 reserved role quiet",
        {sclk_oe, mosi_oe, miso_oe, tx_ready}, 0);
    chk(sclk_o == 1'b1, "R3 clock at idle level", sclk_o, 1);
    tx_data = 8'h5A;
    tx_valid = 1'b1;
    repeat (200) @(negedge clk);
    tx_valid = 1'b0;
    chk(rx_valid == 1'b0, "R3 offer ignored", rx_valid, 0);

    // directed generator corners: every divider, both orders, swap
    run_gen(8'b0001_0000, 8'hA5, 8'h3C);
    run_gen(8'b0101_0101, 8'h81, 8'h7E);
    run_gen(8'b1001_1010, 8'h01, 8'h80);
    run_gen(8'b1101_1111, 8'hF0, 8'h0F);

    // directed follower corners
    run_fol(8'b0010_0000, 8'hC3, 8'h96);
    run_fol(8'b1110_1100, 8'h12, 8'hE7);

    // R11 abandoned frame
    cfg_write(8'b0010_0000);
    sclk_i = 1'b0;
    tx_data = 8'h55;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sclk_i = ~sclk_i;
      repeat (H) @(negedge clk);
    end
    chk(tx_ready == 1'b0, "R11 mid-frame busy", tx_ready, 0);
    ss_n = 1'b1;
    sclk_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R11 abandoned", {tx_ready, rx_valid}, 2'b10);
    run_fol(8'b0010_0000, 8'h6B, 8'hD2);

    // random mix
    for (int r = 0; r < 14; r++) begin
      logic [7:0] cv = 8'($urandom);
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = 8'($urandom);
      if (cv[1:0] == 2'b11 && r % 2 == 1) cv[1:0] = 2'b00;
      cv[5:4] = 2'b01;
      run_gen(cv, a, b);
      cv[5:4] = 2'b10;
      run_fol(cv, b, a);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule